// File: doc/BRIEF.md
# Audio Codec Control Register Block

This block is the software-visible register file of an audio codec controller. It sits on a simple word-addressed 32-bit bus port. It holds four registers for codec register access: a control word, a codec register address, outgoing data and incoming data. It also holds a control, a memory address and a remaining-count register for each of two DMA channels, one for playback and one for capture. The block exports the contents of these registers to the serial-link engine and to the DMA channels. Each DMA channel can load new address and remaining-count values back through its own update strobe.

Software starts a codec transaction by writing the codec control word with the request bit set. A small request sequencer then emits a one-clock pulse on one of two interrupt lines. The direction bit written in the same word picks the line: a codec write fires the request-done line and a codec read fires the reply line. The request bit is never stored, so it always reads back as zero. Reads are registered and return data one cycle after the read strobe.

The request sequencer has three states. `ST_IDLE` raises no pulse. `ST_REQ_PULSE` drives the request-done line. `ST_REPLY_PULSE` drives the reply line. From any state, a control write with request=1 and write=1 moves it to `ST_REQ_PULSE` (transition "issue write"). A control write with request=1 and write=0 moves it to `ST_REPLY_PULSE` (transition "issue read"). Every other cycle returns it to `ST_IDLE` (transition "settle").

Top module: `acodec_regfile`

## Requirements
- R1: After reset every register reads zero, both channel enables are low and neither interrupt line is high.
- R2: The word index is bus_addr shifted right by two, and bus_addr[1:0] is ignored. The map is: 0 codec control, 1 codec address, 2 codec data out, 3 codec data in, 4 playback control, 5 playback address, 6 playback remaining, 7 reserved, 8 capture control, 9 capture address, 10 capture remaining.
- R3: A read strobe (bus_sel=1, bus_we=0) puts the addressed word on bus_rdata after the next rising edge. bus_rdata holds that value until the next read strobe.
- R4: Writes to indices 1, 2, 3, 5, 6, 9 and 10 store all 32 bits. The codec address, the codec data out and codec-control bit 1 (codec_write) are driven on their output ports.
- R5: A write to index 0 stores every bit except bit 0, which always reads back as 0.
- R6: A write to index 0 with bit 0=1 and bit 1=1 makes irq_req_done high for exactly the one clock after the write edge, while irq_reply stays low.
- R7: A write to index 0 with bit 0=1 and bit 1=0 makes irq_reply high for exactly the one clock after the write edge, while irq_req_done stays low.
- R8: A write to index 0 with bit 0=0 raises neither interrupt line.
- R9: Writes to indices 4 and 8 store all 32 bits, and bit 0 drives play_en and cap_en respectively.
- R10: A channel update strobe loads its address and remaining registers on the next edge. A bus write to one of those registers in the same cycle wins for that register only.
- R11: Reads of index 7 and of indices 11 and above return zero, and writes to those indices change no register.
- R12: The two interrupt lines are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_req_done | output | 1 | One-clock pulse for a codec write request |
| irq_reply | output | 1 | One-clock pulse for a codec read request |
| codec_addr | output | DATA_W | Codec register address |
| codec_wdata | output | DATA_W | Codec data out |
| codec_write | output | 1 | Codec access direction (1 = write) |
| play_en | output | 1 | Playback channel enable |
| play_addr | output | DATA_W | Playback memory address |
| play_remain | output | DATA_W | Playback remaining count |
| play_upd | input | 1 | Playback register update strobe |
| play_upd_addr | input | DATA_W | New playback address |
| play_upd_remain | input | DATA_W | New playback remaining count |
| cap_en | output | 1 | Capture channel enable |
| cap_addr | output | DATA_W | Capture memory address |
| cap_remain | output | DATA_W | Capture remaining count |
| cap_upd | input | 1 | Capture register update strobe |
| cap_upd_addr | input | DATA_W | New capture address |
| cap_upd_remain | input | DATA_W | New capture remaining count |

## Verification
The assertions check these rules on every cycle:
- No interrupt pulse appears without a matching control write one cycle earlier.
- The two interrupt lines are never high together.
- Read data stays stable between read strobes, and bit 0 of the codec control word always reads back as zero.
- Reserved indices read back as zero.
- The channel enables follow the control writes.
- A bus write beats a same-cycle DMA update.

Only the bench's scenarios can show the rest: that each pulse ends after one clock, that the lower address bits are really ignored, that ignored writes leave every other register untouched, and that the whole map holds its contents over long random mixes of traffic.

// File: rtl/acodec_pkg.sv
package acodec_pkg;

    // Word indices of the register map
    localparam int unsigned IDX_CC_CTRL   = 0;
    localparam int unsigned IDX_CC_ADDR   = 1;
    localparam int unsigned IDX_CC_DOUT   = 2;
    localparam int unsigned IDX_CC_DIN    = 3;
    localparam int unsigned IDX_PLAY_BASE = 4;
    localparam int unsigned IDX_RESERVED  = 7;
    localparam int unsigned IDX_CAP_BASE  = 8;
    localparam int unsigned REG_SLOTS     = 11;

    // Offsets inside a channel group
    localparam int unsigned CH_OFS_CTRL   = 0;
    localparam int unsigned CH_OFS_ADDR   = 1;
    localparam int unsigned CH_OFS_REMAIN = 2;
    localparam int unsigned NUM_CHANNELS  = 2;
    localparam int unsigned CH_STRIDE     = 4;

    // Bit positions
    localparam int unsigned CC_REQ_BIT   = 0;
    localparam int unsigned CC_WRITE_BIT = 1;
    localparam int unsigned CH_EN_BIT    = 0;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_REQ_PULSE   = 2'd1,
        ST_REPLY_PULSE = 2'd2
    } req_state_e;

endpackage

// File: rtl/acodec_bus_decode.sv
module acodec_bus_decode
    import acodec_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    localparam int unsigned IDX_W = ADDR_W - 2
) (
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [REG_SLOTS-1:0] wr_hit,
    output logic                 rd_strobe,
    output logic [IDX_W-1:0]     rd_idx
);

    logic [IDX_W-1:0] word_idx;
    logic [1:0]       unused_byte_lane;

    assign word_idx         = bus_addr[ADDR_W-1:2];
    assign unused_byte_lane = bus_addr[1:0];
    assign rd_strobe        = bus_sel && !bus_we;
    assign rd_idx           = word_idx;

    // One write enable per slot, the reserved slot never enabled
    for (genvar s = 0; s < REG_SLOTS; s++) begin : g_slot
        if (s == IDX_RESERVED) begin : g_rsv
            assign wr_hit[s] = 1'b0;
        end else begin : g_live
            assign wr_hit[s] = bus_sel && bus_we && (word_idx == IDX_W'(s));
        end
    end

endmodule

// File: rtl/acodec_dma_chan.sv
module acodec_dma_chan
    import acodec_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_addr,
    input  logic              wr_remain,
    input  logic [DATA_W-1:0] wdata,
    input  logic              upd,
    input  logic [DATA_W-1:0] upd_addr,
    input  logic [DATA_W-1:0] upd_remain,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] addr_q,
    output logic [DATA_W-1:0] remain_q,
    output logic              en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            addr_q   <= '0;
            remain_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= wdata;
            end
            // Bus write takes priority over the channel's own update
            if (wr_addr) begin
                addr_q <= wdata;
            end else if (upd) begin
                addr_q <= upd_addr;
            end
            if (wr_remain) begin
                remain_q <= wdata;
            end else if (upd) begin
                remain_q <= upd_remain;
            end
        end
    end

    assign en = ctrl_q[CH_EN_BIT];

endmodule

// File: rtl/acodec_req_fsm.sv
module acodec_req_fsm
    import acodec_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic req_bit,
    input  logic write_bit,
    output logic irq_req_done,
    output logic irq_reply
);

    req_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;  // settle
        unique case (state_q)
            ST_IDLE, ST_REQ_PULSE, ST_REPLY_PULSE: begin
                if (ctrl_wr && req_bit) begin
                    state_d = write_bit ? ST_REQ_PULSE : ST_REPLY_PULSE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_req_done = 1'b0;
        irq_reply    = 1'b0;
        unique case (state_q)
            ST_IDLE:        ;
            ST_REQ_PULSE:   irq_req_done = 1'b1;
            ST_REPLY_PULSE: irq_reply    = 1'b1;
            default:        ;
        endcase
    end

endmodule

// File: rtl/acodec_regfile.sv
module acodec_regfile
    import acodec_pkg::*;
#(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req_done,
    output logic              irq_reply,
    output logic [DATA_W-1:0] codec_addr,
    output logic [DATA_W-1:0] codec_wdata,
    output logic              codec_write,
    output logic              play_en,
    output logic [DATA_W-1:0] play_addr,
    output logic [DATA_W-1:0] play_remain,
    input  logic              play_upd,
    input  logic [DATA_W-1:0] play_upd_addr,
    input  logic [DATA_W-1:0] play_upd_remain,
    output logic              cap_en,
    output logic [DATA_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_remain,
    input  logic              cap_upd,
    input  logic [DATA_W-1:0] cap_upd_addr,
    input  logic [DATA_W-1:0] cap_upd_remain
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [REG_SLOTS-1:0] wr_hit;
    logic                 rd_strobe;
    logic [IDX_W-1:0]     rd_idx;

    logic [DATA_W-1:0] cc_ctrl_q, cc_addr_q, cc_dout_q, cc_din_q;

    logic [NUM_CHANNELS-1:0]             ch_upd;
    logic [NUM_CHANNELS-1:0][DATA_W-1:0] ch_upd_addr, ch_upd_remain;
    logic [NUM_CHANNELS-1:0][DATA_W-1:0] ch_ctrl, ch_addr, ch_remain;
    logic [NUM_CHANNELS-1:0]             ch_en;

    acodec_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .wr_hit    (wr_hit),
        .rd_strobe (rd_strobe),
        .rd_idx    (rd_idx)
    );

    // Codec access registers; the request bit is never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_ctrl_q <= '0;
            cc_addr_q <= '0;
            cc_dout_q <= '0;
            cc_din_q  <= '0;
        end else begin
            if (wr_hit[IDX_CC_CTRL]) begin
                cc_ctrl_q <= bus_wdata & ~(DATA_W'(1) << CC_REQ_BIT);
            end
            if (wr_hit[IDX_CC_ADDR]) cc_addr_q <= bus_wdata;
            if (wr_hit[IDX_CC_DOUT]) cc_dout_q <= bus_wdata;
            if (wr_hit[IDX_CC_DIN])  cc_din_q  <= bus_wdata;
        end
    end

    acodec_req_fsm u_req_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (wr_hit[IDX_CC_CTRL]),
        .req_bit      (bus_wdata[CC_REQ_BIT]),
        .write_bit    (bus_wdata[CC_WRITE_BIT]),
        .irq_req_done (irq_req_done),
        .irq_reply    (irq_reply)
    );

    assign ch_upd        = {cap_upd, play_upd};
    assign ch_upd_addr   = {cap_upd_addr, play_upd_addr};
    assign ch_upd_remain = {cap_upd_remain, play_upd_remain};

    for (genvar c = 0; c < NUM_CHANNELS; c++) begin : g_chan
        localparam int unsigned BASE = IDX_PLAY_BASE + c * CH_STRIDE;
        acodec_dma_chan #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_ctrl    (wr_hit[BASE + CH_OFS_CTRL]),
            .wr_addr    (wr_hit[BASE + CH_OFS_ADDR]),
            .wr_remain  (wr_hit[BASE + CH_OFS_REMAIN]),
            .wdata      (bus_wdata),
            .upd        (ch_upd[c]),
            .upd_addr   (ch_upd_addr[c]),
            .upd_remain (ch_upd_remain[c]),
            .ctrl_q     (ch_ctrl[c]),
            .addr_q     (ch_addr[c]),
            .remain_q   (ch_remain[c]),
            .en         (ch_en[c])
        );
    end

    // Registered read path; unmapped indices return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_strobe) begin
            case (rd_idx)
                IDX_W'(IDX_CC_CTRL):                   bus_rdata <= cc_ctrl_q;
                IDX_W'(IDX_CC_ADDR):                   bus_rdata <= cc_addr_q;
                IDX_W'(IDX_CC_DOUT):                   bus_rdata <= cc_dout_q;
                IDX_W'(IDX_CC_DIN):                    bus_rdata <= cc_din_q;
                IDX_W'(IDX_PLAY_BASE + CH_OFS_CTRL):   bus_rdata <= ch_ctrl[0];
                IDX_W'(IDX_PLAY_BASE + CH_OFS_ADDR):   bus_rdata <= ch_addr[0];
                IDX_W'(IDX_PLAY_BASE + CH_OFS_REMAIN): bus_rdata <= ch_remain[0];
                IDX_W'(IDX_CAP_BASE + CH_OFS_CTRL):    bus_rdata <= ch_ctrl[1];
                IDX_W'(IDX_CAP_BASE + CH_OFS_ADDR):    bus_rdata <= ch_addr[1];
                IDX_W'(IDX_CAP_BASE + CH_OFS_REMAIN):  bus_rdata <= ch_remain[1];
                default:                               bus_rdata <= '0;
            endcase
        end
    end

    assign codec_addr  = cc_addr_q;
    assign codec_wdata = cc_dout_q;
    assign codec_write = cc_ctrl_q[CC_WRITE_BIT];
    assign play_en     = ch_en[0];
    assign play_addr   = ch_addr[0];
    assign play_remain = ch_remain[0];
    assign cap_en      = ch_en[1];
    assign cap_addr    = ch_addr[1];
    assign cap_remain  = ch_remain[1];

endmodule

// File: rtl/acodec_regfile_chk.sv
module acodec_regfile_chk #(
    parameter int unsigned ADDR_W = 6,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_req_done,
    input logic              irq_reply,
    input logic              play_en,
    input logic [DATA_W-1:0] play_addr,
    input logic              play_upd,
    input logic [DATA_W-1:0] play_upd_addr
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr, rd;
    assign idx = bus_addr[ADDR_W-1:2];
    assign wr  = bus_sel && bus_we;
    assign rd  = bus_sel && !bus_we;

    AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_req_done && irq_reply)); // R12

    AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == '0 && bus_wdata[1:0] == 2'b11) |=> irq_req_done); // R6

    AST_REPLY_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == '0 && bus_wdata[1:0] == 2'b01) |=> irq_reply); // R7

    AST_NO_PULSE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == '0 && bus_wdata[0]) |=> !(irq_req_done || irq_reply)); // R8

    AST_REQ_BIT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && idx == '0) |=> !bus_rdata[0]); // R5

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(bus_rdata)); // R3

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (idx == IDX_W'(7) || idx >= IDX_W'(11))) |=> bus_rdata == '0); // R11

    AST_PLAY_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(4)) |=> play_en == $past(bus_wdata[0])); // R9

    AST_BUS_BEATS_DMA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && idx == IDX_W'(5)) |=> play_addr == $past(bus_wdata)); // R10

    AST_DMA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (play_upd && !(wr && idx == IDX_W'(5))) |=> play_addr == $past(play_upd_addr)); // R10

endmodule

bind acodec_regfile acodec_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .irq_req_done  (irq_req_done),
    .irq_reply     (irq_reply),
    .play_en       (play_en),
    .play_addr     (play_addr),
    .play_upd      (play_upd),
    .play_upd_addr (play_upd_addr)
);

// File: tb/acodec_regfile_tb_top.sv
module acodec_regfile_tb_top;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0, bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_req_done, irq_reply;
    logic [DATA_W-1:0] codec_addr, codec_wdata;
    logic              codec_write;
    logic              play_en, cap_en;
    logic [DATA_W-1:0] play_addr, play_remain, cap_addr, cap_remain;
    logic              play_upd = 1'b0, cap_upd = 1'b0;
    logic [DATA_W-1:0] play_upd_addr = '0, play_upd_remain = '0;
    logic [DATA_W-1:0] cap_upd_addr = '0, cap_upd_remain = '0;

    always #10 clk = ~clk;

    acodec_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req_done(irq_req_done), .irq_reply(irq_reply),
        .codec_addr(codec_addr), .codec_wdata(codec_wdata), .codec_write(codec_write),
        .play_en(play_en), .play_addr(play_addr), .play_remain(play_remain),
        .play_upd(play_upd), .play_upd_addr(play_upd_addr), .play_upd_remain(play_upd_remain),
        .cap_en(cap_en), .cap_addr(cap_addr), .cap_remain(cap_remain),
        .cap_upd(cap_upd), .cap_upd_addr(cap_upd_addr), .cap_upd_remain(cap_upd_remain)
    );

    int n_checks = 0;
    int n_fails  = 0;
    logic [DATA_W-1:0] model [16];

    task automatic check(input string tag, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit is_mapped(input int idx);
        return (idx <= 10) && (idx != 7);
    endfunction

    function automatic logic [DATA_W-1:0] stored_value(input int idx,
                                                       input logic [DATA_W-1:0] d);
        return (idx == 0) ? (d & ~32'h1) : d;
    endfunction

    function automatic string read_tag(input int idx);
        if (idx == 0) return "R5";
        if (!is_mapped(idx)) return "R11";
        if (idx == 4 || idx == 8) return "R9";
        if (idx == 5 || idx == 6 || idx == 9 || idx == 10) return "R10";
        return "R4";
    endfunction

    task automatic check_exports();
        check("R4 codec_addr", codec_addr, model[1]);
        check("R4 codec_wdata", codec_wdata, model[2]);
        check("R4 codec_write", 32'(codec_write), 32'(model[0][1]));
        check("R9 play_en", 32'(play_en), 32'(model[4][0]));
        check("R9 cap_en", 32'(cap_en), 32'(model[8][0]));
        check("R10 play_addr", play_addr, model[5]);
        check("R10 cap_remain", cap_remain, model[10]);
    endtask

    // Called at a falling edge; returns at a falling edge
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        int idx = int'(a[ADDR_W-1:2]);
        bit exp_req = (idx == 0) && d[0] && d[1];
        bit exp_rep = (idx == 0) && d[0] && !d[1];
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        if (is_mapped(idx)) model[idx] = stored_value(idx, d);
        check(exp_req ? "R6 req pulse" : "R8 req idle", 32'(irq_req_done), 32'(exp_req));
        check(exp_rep ? "R7 reply pulse" : "R8 reply idle", 32'(irq_reply), 32'(exp_rep));
        @(negedge clk);
        check("R12 pulse ends", 32'({irq_req_done, irq_reply}), 32'd0);
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] a);
        int idx = int'(a[ADDR_W-1:2]);
        logic [DATA_W-1:0] exp = is_mapped(idx) ? model[idx] : '0;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(read_tag(idx), bus_rdata, exp);
        @(negedge clk);
        check("R3 rdata holds", bus_rdata, exp);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'({irq_req_done, irq_reply}), 32'd0);
        check("R1 enables", 32'({play_en, cap_en}), 32'd0);
        for (int i = 0; i < 11; i++) do_read(ADDR_W'(i * 4));

        // R5..R8 directed control writes
        do_write(6'h00, 32'hA5A5_0003);
        do_read(6'h00);
        do_write(6'h00, 32'h0000_0001);
        do_write(6'h00, 32'h0000_0002);
        do_read(6'h00);

        // Back-to-back write then read request pulses
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h3;
        @(negedge clk);
        bus_wdata = 32'h1;
        check("R6 first of pair", 32'({irq_req_done, irq_reply}), 32'b10);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        model[0] = 32'h0;
        check("R7 second of pair", 32'({irq_req_done, irq_reply}), 32'b01);
        @(negedge clk);
        check("R12 pair ends", 32'({irq_req_done, irq_reply}), 32'd0);

        // R2 byte-lane bits ignored
        do_write(6'h07, 32'hDEAD_BEEF);
        do_read(6'h04);
        do_read(6'h06);

        // R11 reserved and out-of-range slots
        do_write(6'h1C, 32'hFFFF_FFFF);
        do_write(6'h3C, 32'h1234_5678);
        do_read(6'h1C);
        do_read(6'h2C);
        for (int i = 0; i < 11; i++) do_read(ADDR_W'(i * 4));

        // R9 channel enables
        do_write(6'h10, 32'h0000_0011);
        do_write(6'h20, 32'h0000_0001);
        check_exports();
        do_write(6'h10, 32'h0000_0010);
        check_exports();

        // R10 DMA update alone
        play_upd = 1'b1; play_upd_addr = 32'h1000_0040; play_upd_remain = 32'h0000_0100;
        cap_upd = 1'b1; cap_upd_addr = 32'h2000_0000; cap_upd_remain = 32'h0000_0200;
        @(negedge clk);
        play_upd = 1'b0; cap_upd = 1'b0;
        model[5] = 32'h1000_0040; model[6] = 32'h0000_0100;
        model[9] = 32'h2000_0000; model[10] = 32'h0000_0200;
        check("R10 play_remain upd", play_remain, model[6]);
        check("R10 cap_addr upd", cap_addr, model[9]);

        // R10 bus write collides with update
        play_upd = 1'b1; play_upd_addr = 32'h3333_3333; play_upd_remain = 32'h0000_0077;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h14; bus_wdata = 32'hCAFE_0000;
        @(negedge clk);
        play_upd = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        model[5] = 32'hCAFE_0000; model[6] = 32'h0000_0077;
        check("R10 bus wins addr", play_addr, model[5]);
        check("R10 dma keeps remain", play_remain, model[6]);
        cap_upd = 1'b1; cap_upd_addr = 32'h4444_0000; cap_upd_remain = 32'h0000_0055;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h28; bus_wdata = 32'h0000_0999;
        @(negedge clk);
        cap_upd = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        model[9] = 32'h4444_0000; model[10] = 32'h0000_0999;
        check("R10 cap addr upd", cap_addr, model[9]);
        check("R10 bus wins remain", cap_remain, model[10]);

        // Constrained random traffic
        for (int n = 0; n < 400; n++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom_range(0, 63));
            logic [DATA_W-1:0] d = $urandom();
            if ($urandom_range(0, 3) == 0) a = {4'd0, a[1:0]};
            if ($urandom_range(0, 1) == 1) do_write(a, d);
            else                           do_read(a);
            if (n % 25 == 0) check_exports();
        end

        // R1 reset again clears everything
        do_write(6'h10, 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 16; i++) model[i] = '0;
        @(negedge clk);
        check("R1 after reset enables", 32'({play_en, cap_en}), 32'd0);
        for (int i = 0; i < 11; i++) do_read(ADDR_W'(i * 4));

        $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule